// File: doc/BRIEF.md
# Soft-Start and Protection Sequencer

This block runs the start-up and fault handling of a two-phase step-down converter controller. It waits for the control supply and the gate-driver supply to be good. It then ramps the regulation reference digitally, one step per switching-cycle tick, from zero up to the programmed target. Over-voltage, under-voltage and power-good checks are switched on in stages.

Output-voltage samples arrive as millivolt values on a valid/ready input. Every valid sample is captured and kept until the next one. The ready signal is always high, so a source can never be back-pressured and may present a sample on any cycle. A tick on `cyc_tick` marks one switching period. The ramp and the under-voltage filter advance only on ticks.

Over- and under-voltage faults latch, and only a drop of the control supply flag clears them. Inhibit parks the converter with every switch off and the protections disabled. Releasing inhibit starts the sequence again.

Top module: `ssq_sequencer`

## Requirements
- R1: While the sequencer waits for its supplies, `ref_mv` is 0. `ls_force` equals `drv_pre_ok` and `all_off` is its inverse. `ls_force` and `all_off` are never high together.
- R2: The ramp starts only when `ctl_sup_ok` and `drv_sup_ok` are both high and `inhibit` is low. If `drv_sup_ok` drops during the ramp or in regulation, the sequencer returns to the waiting state and `ref_mv` goes back to 0.
- R3: During the ramp, `ref_mv` equals floor(`target_mv` × n / 2048), where n is the number of ticks since the ramp began. After 2048 ticks, `ref_mv` equals `target_mv`. `ref_mv` never exceeds `target_mv`.
- R4: `pgood_rel` is low for the whole ramp. It can be high only once the ramp has completed.
- R5: In regulation, `pgood_rel` is high when the last sample s satisfies 0.88·ref ≤ s ≤ 1.12·ref, with both bounds inclusive. It is low otherwise.
- R6: Under-voltage checking is on only while `ref_mv` ≥ 800. A sample below 0.7·ref seen on two consecutive ticks latches an under-voltage fault: `fault` is high and `all_off` is high. A single below-threshold tick followed by a good one does not trip.
- R7: During the ramp or in regulation, a sample of 1976 mV or more latches an over-voltage fault: `fault` is high, `ls_force` is high and `all_off` is low. A sample of 1975 mV does not trip.
- R8: A latched fault holds through inhibit and through ticks. It clears only when `ctl_sup_ok` drops, which returns the sequencer to the waiting state.
- R9: When `inhibit` is high outside a fault, `all_off` is high and `ref_mv` is 0, and no sample can raise `fault`. When `inhibit` is released, the ramp restarts from 0.
- R10: `smp_ready` is always high. A sample is captured on any cycle where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_sup_ok | input | 1 | Control supply above its turn-on level |
| drv_sup_ok | input | 1 | Driver supply above its turn-on level |
| drv_pre_ok | input | 1 | Driver supply high enough to hold the low sides on |
| inhibit | input | 1 | Park request |
| cyc_tick | input | 1 | One-cycle pulse per switching period |
| target_mv | input | 12 | Programmed reference in mV |
| smp_valid | input | 1 | Output-voltage sample valid |
| smp_ready | output | 1 | Sample accepted (always high) |
| smp_mv | input | 12 | Output-voltage sample in mV |
| ref_mv | output | 12 | Ramping reference in mV |
| ls_force | output | 1 | Force both low-side switches on |
| all_off | output | 1 | Turn every switch off |
| fault | output | 1 | Latched protection fault |
| pgood_rel | output | 1 | Release the open-drain power-good line |

## Verification
The properties assume only an active reset at start. They hold for any pattern of supply flags, inhibit and tick, and for a target that changes at any time, because the reference bound and the power-good relation are stated against the current target.

The stimulus keeps ticks as single-cycle pulses three idle cycles apart. It presents each sample several cycles before the ramp or a check depends on it. It holds the target constant during each ramp, so the expected reference is an exact product of the tick count.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_PARK  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_REG   = 3'd3,
    ST_OVF   = 3'd4,
    ST_UVF   = 3'd5
  } ssq_state_t;
endpackage

// File: rtl/ssq_ramp.sv
module ssq_ramp #(
  parameter int MV_W      = 12,
  parameter int RAMP_LOG2 = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic [MV_W-1:0] target_mv,
  output logic [MV_W-1:0] ref_mv,
  output logic            done
);
  localparam int CNT_W  = RAMP_LOG2 + 1;
  localparam int PROD_W = MV_W + CNT_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << RAMP_LOG2;

  logic [CNT_W-1:0]  cnt;
  logic [PROD_W-1:0] prod;

  assign done = (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (step && !done) cnt <= cnt + CNT_W'(1);
  end

  assign prod   = PROD_W'(target_mv) * PROD_W'(cnt);
  assign ref_mv = prod[RAMP_LOG2 +: MV_W];
endmodule

// File: rtl/ssq_monitor.sv
module ssq_monitor #(
  parameter int MV_W      = 12,
  parameter int OV_MV     = 1976,
  parameter int UV_EN_MV  = 800,
  parameter int UV_NUM    = 7,
  parameter int UV_DEN    = 10,
  parameter int PG_LO_NUM = 22,
  parameter int PG_HI_NUM = 28,
  parameter int PG_DEN    = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [MV_W-1:0] smp_mv,
  input  logic [MV_W-1:0] ref_mv,
  input  logic            prot_en,
  input  logic            reg_en,
  input  logic            tick,
  output logic            ov_hit,
  output logic            uv_trip,
  output logic            pg_ok
);
  localparam int PW = MV_W + 6;

  logic [MV_W-1:0] s_mv;
  logic [PW-1:0]   s_uv, r_uv, s_pg, r_lo, r_hi;
  logic            uv_en, below, streak, in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         s_mv <= '0;
    else if (smp_valid) s_mv <= smp_mv;
  end

  assign s_uv  = PW'(s_mv) * PW'(UV_DEN);
  assign r_uv  = PW'(ref_mv) * PW'(UV_NUM);
  assign uv_en = ref_mv >= MV_W'(UV_EN_MV);
  assign below = s_uv < r_uv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       streak <= 1'b0;
    else if (!prot_en) streak <= 1'b0;
    else if (tick)    streak <= uv_en && below;
  end

  assign uv_trip = prot_en && tick && uv_en && below && streak;
  assign ov_hit  = prot_en && (s_mv >= MV_W'(OV_MV));

  assign s_pg   = PW'(s_mv) * PW'(PG_DEN);
  assign r_lo   = PW'(ref_mv) * PW'(PG_LO_NUM);
  assign r_hi   = PW'(ref_mv) * PW'(PG_HI_NUM);
  assign in_win = (s_pg >= r_lo) && (s_pg <= r_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_ok <= 1'b0;
    else        pg_ok <= reg_en && in_win;
  end
endmodule

// File: rtl/ssq_fsm.sv
module ssq_fsm
  import ssq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_ok,
  input  logic       drv_ok,
  input  logic       drv_pre_ok,
  input  logic       inhibit,
  input  logic       ramp_done,
  input  logic       ov_hit,
  input  logic       uv_trip,
  output ssq_state_t state,
  output logic       ls_force,
  output logic       all_off,
  output logic       fault
);
  ssq_state_t nxt;

  always_comb begin
    nxt = state;
    if (!ctl_ok) begin
      nxt = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT: if (inhibit) nxt = ST_PARK;
                 else if (drv_ok) nxt = ST_RAMP;
        ST_PARK: if (!inhibit) nxt = ST_WAIT;
        ST_RAMP, ST_REG: begin
          if (ov_hit)       nxt = ST_OVF;
          else if (uv_trip) nxt = ST_UVF;
          else if (inhibit) nxt = ST_PARK;
          else if (!drv_ok) nxt = ST_WAIT;
          else if (state == ST_RAMP && ramp_done) nxt = ST_REG;
        end
        ST_OVF, ST_UVF: nxt = state;
        default: nxt = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= nxt;
  end

  always_comb begin
    ls_force = 1'b0;
    all_off  = 1'b0;
    fault    = 1'b0;
    unique case (state)
      ST_WAIT: begin ls_force = drv_pre_ok; all_off = !drv_pre_ok; end
      ST_PARK: all_off = 1'b1;
      ST_OVF:  begin ls_force = 1'b1; fault = 1'b1; end
      ST_UVF:  begin all_off = 1'b1; fault = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ssq_sequencer.sv
module ssq_sequencer
  import ssq_pkg::*;
#(
  parameter int MV_W      = 12,
  parameter int RAMP_LOG2 = 11,
  parameter int OV_MV     = 1976,
  parameter int UV_EN_MV  = 800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_sup_ok,
  input  logic            drv_sup_ok,
  input  logic            drv_pre_ok,
  input  logic            inhibit,
  input  logic            cyc_tick,
  input  logic [MV_W-1:0] target_mv,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [MV_W-1:0] smp_mv,
  output logic [MV_W-1:0] ref_mv,
  output logic            ls_force,
  output logic            all_off,
  output logic            fault,
  output logic            pgood_rel
);
  ssq_state_t state;
  logic       ramp_done, ov_hit, uv_trip;
  logic       prot_en, reg_en, clr, step;

  assign smp_ready = 1'b1;
  assign prot_en   = (state == ST_RAMP) || (state == ST_REG);
  assign reg_en    = (state == ST_REG);
  assign clr       = (state == ST_WAIT) || (state == ST_PARK);
  assign step      = cyc_tick && (state == ST_RAMP);

  ssq_ramp #(.MV_W(MV_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .target_mv(target_mv), .ref_mv(ref_mv), .done(ramp_done)
  );

  ssq_monitor #(.MV_W(MV_W), .OV_MV(OV_MV), .UV_EN_MV(UV_EN_MV)) u_mon (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .ref_mv(ref_mv), .prot_en(prot_en), .reg_en(reg_en), .tick(cyc_tick),
    .ov_hit(ov_hit), .uv_trip(uv_trip), .pg_ok(pgood_rel)
  );

  ssq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_ok(ctl_sup_ok), .drv_ok(drv_sup_ok),
    .drv_pre_ok(drv_pre_ok), .inhibit(inhibit), .ramp_done(ramp_done),
    .ov_hit(ov_hit), .uv_trip(uv_trip), .state(state),
    .ls_force(ls_force), .all_off(all_off), .fault(fault)
  );
endmodule

// File: rtl/ssq_sequencer_chk.sv
module ssq_sequencer_chk #(
  parameter int MV_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_sup_ok,
  input logic            inhibit,
  input logic [MV_W-1:0] target_mv,
  input logic [MV_W-1:0] ref_mv,
  input logic            ls_force,
  input logic            all_off,
  input logic            fault,
  input logic            pgood_rel
);
  AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_force && all_off)); // R1
  AST_REF_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mv <= target_mv); // R3
  AST_PG_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_rel |-> (ref_mv == target_mv)); // R4
  AST_OV_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !all_off) |-> ls_force); // R7
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && ctl_sup_ok) |=> fault); // R8
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !fault && ctl_sup_ok) |=> (all_off || fault)); // R9
endmodule

bind ssq_sequencer ssq_sequencer_chk #(.MV_W(MV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_sup_ok(ctl_sup_ok), .inhibit(inhibit),
  .target_mv(target_mv), .ref_mv(ref_mv), .ls_force(ls_force),
  .all_off(all_off), .fault(fault), .pgood_rel(pgood_rel)
);

// File: tb/ssq_sequencer_test.sv
`timescale 1ns/1ps
module ssq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_sup_ok = 1'b0, drv_sup_ok = 1'b0, drv_pre_ok = 1'b0;
  logic        inhibit = 1'b0, cyc_tick = 1'b0, smp_valid = 1'b0;
  logic [11:0] target_mv = 12'd1200, smp_mv = 12'd0;
  logic        smp_ready, ls_force, all_off, fault, pgood_rel;
  logic [11:0] ref_mv;
  int total = 0, bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  ssq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .ctl_sup_ok(ctl_sup_ok), .drv_sup_ok(drv_sup_ok),
    .drv_pre_ok(drv_pre_ok), .inhibit(inhibit), .cyc_tick(cyc_tick),
    .target_mv(target_mv), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_mv(smp_mv), .ref_mv(ref_mv), .ls_force(ls_force), .all_off(all_off),
    .fault(fault), .pgood_rel(pgood_rel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      cyc_tick = 1'b1; @(negedge clk);
      cyc_tick = 1'b0; cyc(3);
    end
  endtask

  task automatic sample(input int v);
    smp_mv = 12'(v); smp_valid = 1'b1; @(negedge clk);
    smp_valid = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset ref", ref_mv, 0);
    chk("R1 reset all_off", all_off, 1);
    chk("R1 reset ls_force", ls_force, 0);
    chk("R8 reset fault", fault, 0);
    chk("R4 reset pgood", pgood_rel, 0);
    chk("R10 ready", smp_ready, 1);
  endtask

  task automatic t_precharge;
    drv_pre_ok = 1'b1; cyc(2);
    chk("R1 precharge ls_force", ls_force, 1);
    chk("R1 precharge all_off", all_off, 0);
  endtask

  task automatic t_start_gate;
    ctl_sup_ok = 1'b1; cyc(2); ticks(5);
    chk("R2 no ramp without driver supply", ref_mv, 0);
  endtask

  task automatic t_ramp;
    target_mv = 12'd1200; sample(1100);
    drv_sup_ok = 1'b1; cyc(2);
    ticks(1024);
    chk("R3 ramp midpoint", ref_mv, 600);
    chk("R4 pgood low mid ramp", pgood_rel, 0);
    ticks(1023);
    chk("R3 ramp 2047", ref_mv, 1199);
    chk("R4 pgood low at 2047", pgood_rel, 0);
    ticks(1);
    chk("R3 ramp end", ref_mv, 1200);
    chk("R4 pgood after ramp", pgood_rel, 1);
  endtask

  task automatic t_window;
    sample(1055); cyc(2); chk("R5 below low bound", pgood_rel, 0);
    sample(1056); cyc(2); chk("R5 at low bound", pgood_rel, 1);
    sample(1345); cyc(2); chk("R5 above high bound", pgood_rel, 0);
    sample(1344); cyc(2); chk("R5 at high bound", pgood_rel, 1);
    sample(1000); cyc(2); chk("R5 well below", pgood_rel, 0);
    sample(1100); cyc(2);
  endtask

  task automatic t_uv;
    sample(800); ticks(1);
    sample(1100); ticks(1);
    sample(800); ticks(1);
    chk("R6 interrupted low does not trip", fault, 0);
    ticks(1);
    chk("R6 second low tick trips", fault, 1);
    chk("R6 uv all_off", all_off, 1);
    chk("R6 uv ls_force", ls_force, 0);
  endtask

  task automatic t_latch;
    inhibit = 1'b1; cyc(5);
    chk("R8 fault holds in inhibit", fault, 1);
    inhibit = 1'b0; ticks(3);
    chk("R8 fault holds over ticks", fault, 1);
    ctl_sup_ok = 1'b0; cyc(3);
    chk("R8 fault cleared by supply cycle", fault, 0);
    chk("R1 waiting ref", ref_mv, 0);
    chk("R1 waiting ls_force", ls_force, 1);
  endtask

  task automatic t_ov;
    target_mv = 12'd1000; sample(0);
    ctl_sup_ok = 1'b1; cyc(2);
    ticks(100);
    chk("R3 early ramp ref", ref_mv, 48);
    chk("R6 uv gated below 800", fault, 0);
    sample(1975); cyc(2);
    chk("R7 1975 no trip", fault, 0);
    sample(1976); cyc(2);
    chk("R7 ov fault", fault, 1);
    chk("R7 ov ls_force", ls_force, 1);
    chk("R7 ov all_off", all_off, 0);
    chk("R10 ready in fault", smp_ready, 1);
    inhibit = 1'b1; cyc(3);
    chk("R8 ov held in inhibit", fault, 1);
    inhibit = 1'b0;
    ctl_sup_ok = 1'b0; cyc(3);
    chk("R8 ov cleared", fault, 0);
  endtask

  task automatic t_inhibit;
    target_mv = 12'd1200; sample(1100);
    ctl_sup_ok = 1'b1; cyc(2);
    ticks(2048);
    chk("R4 regulation pgood", pgood_rel, 1);
    inhibit = 1'b1; cyc(3);
    chk("R9 inhibit all_off", all_off, 1);
    chk("R9 inhibit ref", ref_mv, 0);
    chk("R9 inhibit pgood", pgood_rel, 0);
    sample(2000); cyc(2); ticks(4);
    chk("R9 no protection in inhibit", fault, 0);
    sample(1100);
    inhibit = 1'b0; cyc(2);
    chk("R9 restart ref", ref_mv, 0);
    chk("R9 restart all_off", all_off, 0);
    ticks(1024);
    chk("R9 restarted ramp", ref_mv, 600);
  endtask

  task automatic t_supply_loss;
    drv_sup_ok = 1'b0; cyc(3);
    chk("R2 supply loss ref", ref_mv, 0);
    chk("R2 supply loss ls_force", ls_force, 1);
    chk("R2 supply loss fault", fault, 0);
    drv_pre_ok = 1'b0; cyc(2);
    chk("R1 no precharge all_off", all_off, 1);
    chk("R1 no precharge ls_force", ls_force, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_precharge();
    t_start_gate();
    t_ramp();
    t_window();
    t_uv();
    t_latch();
    t_ov();
    t_inhibit();
    t_supply_loss();
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule